// File: doc/BRIEF.md
# Bit-field extract and insert unit

This execute unit pulls a bit field out of a 64-bit source operand, or writes a field into a copy of a destination value. Each operation comes in four forms. Three doubleword forms cover fields in the low half, fields that cross the 32-bit midpoint and fields in the upper half. The fourth form works on a 32-bit word. The unit decodes the instruction word itself. It takes the field position and the size or top bit from fixed instruction fields, builds the field mask, shifts the operands and, for the word forms, sign-extends the 32-bit result to 64 bits.

The pipeline supplies the source operand, the current destination value and a flag that says whether 64-bit operations are enabled. One cycle later the unit returns the new destination value with a write enable, or raises a reserved-instruction flag. It has no register file ports and no hazard logic.

Top module: `bfx_unit`

## Requirements
- R1: An instruction is recognised when bits [31:26] equal 6'b011111 and bits [5:3] equal 3'b000. Bits [2:0] select the form: 0 word extract, 1 extract-middle, 2 extract-upper, 3 doubleword extract, 4 word insert, 5 insert-middle, 6 insert-upper, 7 doubleword insert. Bits [15:11] hold size or msb and bits [10:6] hold lsb. Any other instruction word leaves we_o and rsvd_o low and result_o zero.
- R2: Outputs are registered and appear one clock after valid_i is sampled. While rst_ni is low, we_o, rsvd_o and result_o are zero.
- R3: Doubleword extract returns size+1 bits of rs_i starting at bit lsb, right-aligned, with zeros above the field.
- R4: Extract-middle returns size+33 bits starting at bit lsb. Any field bits beyond bit 63 read as zero.
- R5: Extract-upper returns size+1 bits starting at bit lsb+32. Any field bits beyond bit 63 read as zero.
- R6: Word extract takes size+1 bits from bit lsb of the low word of rs_i, reads bits above bit 31 as zero, and sign-extends bit 31 of the 32-bit result into bits [63:32].
- R7: Doubleword insert replaces bits msb..lsb of rt_i with the low bits of rs_i and keeps all other bits of rt_i.
- R8: Insert-middle works like R7 but uses msb+32 as the top bit.
- R9: Insert-upper works like R7 but uses msb+32 as the top bit and lsb+32 as the bottom bit.
- R10: Word insert applies R7 to the low word only and sign-extends bit 31 of the merged word into bits [63:32].
- R11: An insert whose bottom bit is above its top bit still asserts we_o and returns rt_i unmodified, with no sign extension.
- R12: A doubleword form (codes 1, 2, 3, 5, 6, 7) with mode64_i low asserts rsvd_o, keeps we_o low and returns zero. Word forms do not depend on mode64_i. we_o and rsvd_o are never high together.
- R13: When valid_i is low, the next cycle has we_o and rsvd_o low and result_o zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| mode64_i | input | 1 | 64-bit operations enabled |
| instr_i | input | 32 | Instruction word |
| rs_i | input | 64 | Source operand |
| rt_i | input | 64 | Current destination value |
| we_o | output | 1 | Write result_o back to the destination |
| rsvd_o | output | 1 | Reserved-instruction exception |
| result_o | output | 64 | New destination value |

## Verification
Assertions check on every cycle that the exception gate and the write enable are mutually exclusive and that foreign or idle cycles stay quiet. They also check that word-extract results are sign-extended, that doubleword extracts leave nothing above the field width, that doubleword-class inserts keep every bit outside the mask, and that an inverted insert range returns the old destination. The exact field contents (correct bit offsets, the +32 biases, truncation at bit 31 or 63, and sign extension after a word insert) are shown only by the bench. The bench compares directed edge cases and thousands of random instructions against a bit-by-bit reference model.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  localparam logic [5:0] OPC_BF = 6'b011111;

  // values match the low three function bits
  typedef enum logic [2:0] {
    OP_EXT_W = 3'd0,
    OP_EXT_M = 3'd1,
    OP_EXT_U = 3'd2,
    OP_EXT_D = 3'd3,
    OP_INS_W = 3'd4,
    OP_INS_M = 3'd5,
    OP_INS_U = 3'd6,
    OP_INS_D = 3'd7
  } bf_op_e;

  typedef struct packed {
    logic   hit;
    bf_op_e op;
    logic   is_ins;
    logic   is_word;
    logic   needs64;
  } bf_ctl_t;
endpackage

// File: rtl/bfx_decode.sv
module bfx_decode
  import bfx_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [31:0]             instr_i,
  output bf_ctl_t                 ctl_o,
  output logic [$clog2(XLEN)-1:0] pos_o,
  output logic [$clog2(XLEN)-1:0] top_o
);
  localparam int IW   = $clog2(XLEN);
  localparam int HALF = XLEN / 2;

  logic [5:0]    func;
  logic [IW-2:0] fld_hi;
  logic [IW-2:0] fld_lo;
  logic          bias_pos;
  logic          bias_top;
  logic          unused_bits;

  assign func        = instr_i[5:0];
  assign fld_hi      = instr_i[11+IW-2:11];
  assign fld_lo      = instr_i[6+IW-2:6];
  assign unused_bits = ^instr_i[25:16];

  always_comb begin
    ctl_o.hit     = (instr_i[31:26] == OPC_BF) && (func[5:3] == 3'b000);
    ctl_o.op      = bf_op_e'(func[2:0]);
    ctl_o.is_ins  = func[2];
    ctl_o.is_word = (func[1:0] == 2'b00);
    ctl_o.needs64 = (func[1:0] != 2'b00);
  end

  // +HALF bias: the bottom bit for the upper forms, the top bit for middle forms and insert-upper
  assign bias_pos = (ctl_o.op == OP_EXT_U) || (ctl_o.op == OP_INS_U);
  assign bias_top = (ctl_o.op == OP_EXT_M) || (ctl_o.op == OP_INS_M) ||
                    (ctl_o.op == OP_INS_U);

  assign pos_o = {1'b0, fld_lo} + (bias_pos ? IW'(HALF) : '0);
  assign top_o = {1'b0, fld_hi} + (bias_top ? IW'(HALF) : '0);
endmodule

// File: rtl/bfx_mask.sv
module bfx_mask #(
  parameter int XLEN = 64
) (
  input  logic [$clog2(XLEN)-1:0] lo_i,
  input  logic [$clog2(XLEN)-1:0] hi_i,
  output logic [XLEN-1:0]         mask_o
);
  localparam int IW = $clog2(XLEN);

  // ones from lo_i to hi_i inclusive; all zero when lo_i > hi_i
  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    localparam logic [IW-1:0] IDX = IW'(i);
    assign mask_o[i] = (IDX >= lo_i) && (IDX <= hi_i);
  end
endmodule

// File: rtl/bfx_merge.sv
module bfx_merge
  import bfx_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  bf_ctl_t                 ctl_i,
  input  logic [$clog2(XLEN)-1:0] pos_i,
  input  logic [$clog2(XLEN)-1:0] top_i,
  input  logic [XLEN-1:0]         mask_i,
  input  logic [XLEN-1:0]         rs_i,
  input  logic [XLEN-1:0]         rt_i,
  output logic [XLEN-1:0]         res_o
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] src;
  logic [XLEN-1:0] ext_val;
  logic [XLEN-1:0] ins_val;
  logic [XLEN-1:0] raw;
  logic            inverted;

  // word forms see only the low word, so bits past HALF-1 read as zero
  assign src      = ctl_i.is_word ? {{HALF{1'b0}}, rs_i[HALF-1:0]} : rs_i;
  assign ext_val  = (src >> pos_i) & mask_i;
  assign ins_val  = (rt_i & ~mask_i) | ((rs_i << pos_i) & mask_i);
  assign inverted = pos_i > top_i;

  always_comb begin
    raw = ctl_i.is_ins ? ins_val : ext_val;
    if (ctl_i.is_ins && inverted) begin
      res_o = rt_i;
    end else if (ctl_i.is_word) begin
      res_o = {{HALF{raw[HALF-1]}}, raw[HALF-1:0]};
    end else begin
      res_o = raw;
    end
  end
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
  import bfx_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            mode64_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] rs_i,
  input  logic [XLEN-1:0] rt_i,
  output logic            we_o,
  output logic            rsvd_o,
  output logic [XLEN-1:0] result_o
);
  localparam int IW = $clog2(XLEN);

  bf_ctl_t         ctl;
  logic [IW-1:0]   pos;
  logic [IW-1:0]   top;
  logic [IW-1:0]   mask_lo;
  logic [XLEN-1:0] mask;
  logic [XLEN-1:0] res;
  logic            hit;
  logic            trap;
  logic            we_n;

  bfx_decode #(.XLEN(XLEN)) u_dec (
    .instr_i (instr_i),
    .ctl_o   (ctl),
    .pos_o   (pos),
    .top_o   (top)
  );

  // extract masks the shifted-down field from bit 0; insert masks in place
  assign mask_lo = ctl.is_ins ? pos : '0;

  bfx_mask #(.XLEN(XLEN)) u_mask (
    .lo_i   (mask_lo),
    .hi_i   (top),
    .mask_o (mask)
  );

  bfx_merge #(.XLEN(XLEN)) u_merge (
    .ctl_i  (ctl),
    .pos_i  (pos),
    .top_i  (top),
    .mask_i (mask),
    .rs_i   (rs_i),
    .rt_i   (rt_i),
    .res_o  (res)
  );

  assign hit  = valid_i && ctl.hit;
  assign trap = hit && ctl.needs64 && !mode64_i;
  assign we_n = hit && !trap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o     <= 1'b0;
      rsvd_o   <= 1'b0;
      result_o <= '0;
    end else begin
      we_o     <= we_n;
      rsvd_o   <= trap;
      result_o <= we_n ? res : '0;
    end
  end

  a_r12_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_o && rsvd_o));

  a_r12_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ctl.hit && ctl.needs64 && !mode64_i) |=>
      (rsvd_o && !we_o && result_o == '0));

  a_r1_foreign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ctl.hit) |=> (!we_o && !rsvd_o));

  a_r13_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!we_o && !rsvd_o && result_o == '0));

  a_r6_sext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ctl.hit && ctl.op == OP_EXT_W) |=>
      (result_o[XLEN-1:XLEN/2] == {(XLEN/2){result_o[XLEN/2-1]}}));

  a_r3_zero_above: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ctl.hit && ctl.op == OP_EXT_D && mode64_i) |=>
      ((result_o >> ({1'b0, $past(top)} + 7'd1)) == '0));

  a_r7_keep_outside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ctl.hit && ctl.is_ins && !ctl.is_word && mode64_i) |=>
      (((result_o ^ $past(rt_i)) & ~$past(mask)) == '0));

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ctl.hit && ctl.is_ins && (pos > top) && (ctl.is_word || mode64_i)) |=>
      (we_o && result_o == $past(rt_i)));
endmodule

// File: tb/sim_bfx_unit.sv
`timescale 1ns/1ps
module sim_bfx_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        mode64 = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] rs = '0;
  logic [63:0] rt = '0;
  logic        we;
  logic        rsvd;
  logic [63:0] result;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  bfx_unit u0 (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .valid_i  (valid),
    .mode64_i (mode64),
    .instr_i  (instr),
    .rs_i     (rs),
    .rt_i     (rt),
    .we_o     (we),
    .rsvd_o   (rsvd),
    .result_o (result)
  );

  function automatic [31:0] mk(input [5:0] f, input [4:0] hi, input [4:0] lo);
    return {6'b011111, 10'd0, hi, lo, f};
  endfunction

  function automatic string tag_of(input [31:0] ins);
    if (ins[31:26] != 6'b011111 || ins[5:3] != 3'b000) return "R1";
    case (ins[2:0])
      3'd0: return "R6";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R3";
      3'd4: return "R10";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return "R7";
    endcase
  endfunction

  // bit-by-bit reference
  function automatic void model(input [31:0] ins, input [63:0] a, input [63:0] d,
                                input m, input v, output logic ew, output logic er,
                                output logic [63:0] ex);
    int sz, lb, start, width, lo, hi, lim;
    logic [2:0] f;
    ew = 1'b0; er = 1'b0; ex = '0;
    if (!v || ins[31:26] != 6'b011111 || ins[5:3] != 3'b000) return;
    f  = ins[2:0];
    sz = int'(ins[15:11]);
    lb = int'(ins[10:6]);
    if (f[1:0] != 2'b00 && !m) begin
      er = 1'b1;
      return;
    end
    ew = 1'b1;
    if (!f[2]) begin
      start = (f == 3'd2) ? lb + 32 : lb;
      width = (f == 3'd1) ? sz + 33 : sz + 1;
      lim   = (f == 3'd0) ? 32 : 64;
      for (int i = 0; i < 64; i++)
        ex[i] = (i < width && start + i < lim) ? a[start + i] : 1'b0;
      if (f == 3'd0) for (int i = 32; i < 64; i++) ex[i] = ex[31];
    end else begin
      lo = (f == 3'd6) ? lb + 32 : lb;
      hi = (f == 3'd5 || f == 3'd6) ? sz + 32 : sz;
      if (lo > hi) begin
        ex = d;
      end else begin
        for (int i = 0; i < 64; i++)
          ex[i] = (i >= lo && i <= hi) ? a[i - lo] : d[i];
        if (f == 3'd4) for (int i = 32; i < 64; i++) ex[i] = ex[31];
      end
    end
  endfunction

  task automatic check(input string req, input [63:0] act, input [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input [31:0] ins, input [63:0] a, input [63:0] d,
                        input m, input v, input string tag);
    logic ew, er;
    logic [63:0] ex;
    @(negedge clk);
    instr = ins; rs = a; rt = d; mode64 = m; valid = v;
    model(ins, a, d, m, v, ew, er, ex);
    @(negedge clk);
    check({tag, " we"}, {63'd0, we}, {63'd0, ew});
    check({tag, " rsvd"}, {63'd0, rsvd}, {63'd0, er});
    check({tag, " result"}, result, ex);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R2: reset state
    check("R2 we", {63'd0, we}, 64'd0);
    check("R2 rsvd", {63'd0, rsvd}, 64'd0);
    check("R2 result", result, 64'd0);
    rst_n = 1'b1;

    run_op(mk(6'd3, 5'd7, 5'd4), 64'hFEDC_BA98_7654_3210, 64'h0, 1'b1, 1'b1, "R3");
    run_op(mk(6'd3, 5'd31, 5'd31), 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, 1'b1, "R3");
    run_op(mk(6'd1, 5'd31, 5'd0), 64'h8123_4567_89AB_CDEF, 64'h0, 1'b1, 1'b1, "R4");
    run_op(mk(6'd1, 5'd31, 5'd20), 64'hF0F0_1234_5678_9ABC, 64'h0, 1'b1, 1'b1, "R4");
    run_op(mk(6'd2, 5'd31, 5'd16), 64'hDEAD_BEEF_CAFE_F00D, 64'h0, 1'b1, 1'b1, "R5");
    run_op(mk(6'd0, 5'd31, 5'd0), 64'h1234_5678_8000_0001, 64'h0, 1'b0, 1'b1, "R6");
    run_op(mk(6'd0, 5'd15, 5'd24), 64'hFFFF_FFFF_FF00_0000, 64'h0, 1'b1, 1'b1, "R6");
    run_op(mk(6'd7, 5'd19, 5'd8), 64'h0000_0000_0000_0ABC, 64'h5555_5555_5555_5555, 1'b1, 1'b1, "R7");
    run_op(mk(6'd5, 5'd3, 5'd28), 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, 1'b1, "R8");
    run_op(mk(6'd6, 5'd31, 5'd31), 64'h1, 64'h0, 1'b1, 1'b1, "R9");
    run_op(mk(6'd4, 5'd31, 5'd28), 64'hF, 64'h0000_0000_0123_4567, 1'b0, 1'b1, "R10");
    run_op(mk(6'd7, 5'd2, 5'd9), 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF, 1'b1, 1'b1, "R11");
    run_op(mk(6'd4, 5'd0, 5'd5), 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_8000_0000, 1'b1, 1'b1, "R11");
    run_op(mk(6'd6, 5'd1, 5'd4), 64'hFFFF_FFFF_FFFF_FFFF, 64'hAAAA_0000_0000_0000, 1'b1, 1'b1, "R11");
    run_op(mk(6'd3, 5'd7, 5'd0), 64'hFF, 64'h0, 1'b0, 1'b1, "R12");
    run_op(mk(6'd5, 5'd7, 5'd0), 64'hFF, 64'h0, 1'b0, 1'b1, "R12");
    run_op({6'b011110, 20'd0, 6'd3}, 64'hFF, 64'h1, 1'b1, 1'b1, "R1");
    run_op(mk(6'd8, 5'd7, 5'd0), 64'hFF, 64'h1, 1'b1, 1'b1, "R1");
    run_op(mk(6'd3, 5'd7, 5'd0), 64'hFF, 64'h1, 1'b1, 1'b0, "R13");

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] ins;
      logic [63:0] a, d;
      logic m, v;
      ins = mk({3'b000, 3'($urandom_range(0, 7))}, 5'($urandom), 5'($urandom));
      if ($urandom_range(0, 19) == 0) ins[31:26] = 6'($urandom);
      if ($urandom_range(0, 19) == 0) ins[5:3] = 3'($urandom);
      ins[25:16] = 10'($urandom);
      a = {$urandom, $urandom};
      d = {$urandom, $urandom};
      m = ($urandom_range(0, 7) != 0);
      v = ($urandom_range(0, 15) != 0);
      run_op(ins, a, d, m, v, v ? tag_of(ins) : "R13");
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule